// File: doc/BRIEF.md
# Dispatch Port Scoreboard with Divider Occupancy

This block sits between the instruction issue logic and five execution dispatch ports of an out-of-order core. Each cycle the issue logic may present one micro-operation, described by an operation class and a two-bit operand mode. In the same cycle the scoreboard decides whether every resource that the operation needs is free. If so, it raises `grant`, reports which port or ports were claimed, and gives the number of cycles until the result is ready.

Two long-running, non-pipelined dividers, one for integers and one for floating point, sit behind port 0. A granted divide occupies its divider for an interval that depends on the operand mode, and further divides of the same kind are refused until the interval ends. A floating multiply holds port 0 for two cycles. A refused request is not queued: the requester keeps it and presents it again. A synchronous reset clears all occupancy.

Top module: `dispatch_scoreboard`

## Requirements
- R1: With `req_valid` low, `grant` is 0, `grant_ports` is 0 and `result_latency` is 0. After reset every resource is free.
- R2: A simple ALU operation (class 0) takes port 0 (`grant_ports`=5'b00001) when port 0 is free. When port 0 is busy it takes port 1 (5'b00010). It is refused only when both ports are busy.
- R3: Shift/rotate/address (class 1), integer multiply (2), floating add (6), floating multiply (7), integer divide (8) and floating divide (9) use port 0 only. Branch (3) uses port 1 only. Load (4) uses port 2 only (5'b00100). Each of these claims exactly one port.
- R4: A store (class 5) claims port 3 and port 4 together in the same cycle (`grant_ports`=5'b11000).
- R5: Result latencies are ALU 1, shift 1, integer multiply 4, branch 1, load 4, store 1, floating add 3 and floating multiply 5. Integer multiply may be granted on back-to-back cycles.
- R6: A granted integer divide reports a latency of 12, 21 or 37 for mode 0, 1 or 2. Mode 3 behaves like mode 2. After a grant at cycle t with interval N, an integer divide is refused at t+N-1 and can be granted at t+N.
- R7: A granted floating divide reports a latency of 18, 32 or 38 for mode 0, 1 or 2. Mode 3 behaves like mode 2. Further floating divides are refused for latency-1 cycles after the grant.
- R8: A granted floating multiply keeps port 0 busy in the following cycle, so a port-0-only request in that cycle is refused.
- R9: A busy divider blocks only divides of its own kind. Other divides and other port-0 operations are still granted while it counts.
- R10: Class codes 10 to 15 are never granted and leave no state behind.
- R11: A refused request changes no occupancy; in particular a refused divide does not restart its divider's interval.
- R12: Synchronous reset clears port and divider occupancy while they are busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A micro-operation is presented this cycle |
| req_class | input | 4 | Operation class code (0 to 9 defined) |
| req_mode | input | 2 | Operand mode; selects the divider interval |
| grant | output | 1 | Request accepted this cycle |
| grant_ports | output | 5 | One bit per dispatch port claimed (bit 0 = port 0) |
| result_latency | output | 6 | Cycles until the result is ready; 0 when not granted |

## Verification
The checker watches the port-claim shape on every cycle: exactly one port for non-store classes, the port 3/4 pair for stores, only ports 0 or 1 for ALU work, nothing for undefined classes, and fixed latencies. It also checks that a floating multiply leaves port 0 closed in the next cycle. Its own cycle counters confirm that no divide is ever granted inside its divider's mode-dependent window. What only the bench scenarios can show is that a grant really comes back at the exact first free cycle, that a refused divide does not stretch the window, and that reset reopens resources in the middle of an interval.

// File: rtl/dsb_pkg.sv
package dsb_pkg;

    localparam int NUM_PORTS = 5;
    localparam int CLASS_W   = 4;
    localparam int MODE_W    = 2;
    localparam int LAT_W     = 6;
    localparam int HOLD_W    = 2;
    localparam int DIV_CNT_W = 6;

    localparam logic [CLASS_W-1:0] OP_ALU    = 4'd0;
    localparam logic [CLASS_W-1:0] OP_SHIFT  = 4'd1;
    localparam logic [CLASS_W-1:0] OP_IMUL   = 4'd2;
    localparam logic [CLASS_W-1:0] OP_BRANCH = 4'd3;
    localparam logic [CLASS_W-1:0] OP_LOAD   = 4'd4;
    localparam logic [CLASS_W-1:0] OP_STORE  = 4'd5;
    localparam logic [CLASS_W-1:0] OP_FADD   = 4'd6;
    localparam logic [CLASS_W-1:0] OP_FMUL   = 4'd7;
    localparam logic [CLASS_W-1:0] OP_IDIV   = 4'd8;
    localparam logic [CLASS_W-1:0] OP_FDIV   = 4'd9;

    localparam logic [NUM_PORTS-1:0] PORT_ALU0   = 5'b00001;
    localparam logic [NUM_PORTS-1:0] PORT_ALU1   = 5'b00010;
    localparam logic [NUM_PORTS-1:0] PORT_LOAD   = 5'b00100;
    localparam logic [NUM_PORTS-1:0] PORT_STPAIR = 5'b11000;

    typedef struct packed {
        logic                 legal;
        logic [NUM_PORTS-1:0] need;
        logic [NUM_PORTS-1:0] alt;
        logic                 uses_idiv;
        logic                 uses_fdiv;
        logic [HOLD_W-1:0]    hold;
        logic [LAT_W-1:0]     latency;
        logic [DIV_CNT_W-1:0] div_block;
    } op_route_t;

    function automatic logic [LAT_W-1:0] int_div_span(input logic [MODE_W-1:0] mode);
        case (mode)
            2'd0:    return LAT_W'(12);
            2'd1:    return LAT_W'(21);
            default: return LAT_W'(37);
        endcase
    endfunction

    function automatic logic [LAT_W-1:0] fp_div_span(input logic [MODE_W-1:0] mode);
        case (mode)
            2'd0:    return LAT_W'(18);
            2'd1:    return LAT_W'(32);
            default: return LAT_W'(38);
        endcase
    endfunction

    function automatic op_route_t single_port(input logic [NUM_PORTS-1:0] port,
                                              input logic [LAT_W-1:0] lat);
        op_route_t r;
        r           = '0;
        r.legal     = 1'b1;
        r.need      = port;
        r.hold      = HOLD_W'(1);
        r.latency   = lat;
        return r;
    endfunction

    function automatic op_route_t decode_op(input logic [CLASS_W-1:0] cls,
                                            input logic [MODE_W-1:0]  mode);
        op_route_t r;
        logic [LAT_W-1:0] span;
        r    = '0;
        span = '0;
        case (cls)
            OP_ALU: begin
                r     = single_port(PORT_ALU0, LAT_W'(1));
                r.alt = PORT_ALU1;
            end
            OP_SHIFT:  r = single_port(PORT_ALU0, LAT_W'(1));
            OP_IMUL:   r = single_port(PORT_ALU0, LAT_W'(4));
            OP_BRANCH: r = single_port(PORT_ALU1, LAT_W'(1));
            OP_LOAD:   r = single_port(PORT_LOAD, LAT_W'(4));
            OP_STORE:  r = single_port(PORT_STPAIR, LAT_W'(1));
            OP_FADD:   r = single_port(PORT_ALU0, LAT_W'(3));
            OP_FMUL: begin
                r      = single_port(PORT_ALU0, LAT_W'(5));
                r.hold = HOLD_W'(2);
            end
            OP_IDIV: begin
                span        = int_div_span(mode);
                r           = single_port(PORT_ALU0, span);
                r.uses_idiv = 1'b1;
                r.div_block = DIV_CNT_W'(span - LAT_W'(1));
            end
            OP_FDIV: begin
                span        = fp_div_span(mode);
                r           = single_port(PORT_ALU0, span);
                r.uses_fdiv = 1'b1;
                r.div_block = DIV_CNT_W'(span - LAT_W'(2));
            end
            default: r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dsb_port_hold.sv
module dsb_port_hold #(
    parameter int HOLD_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              claim,
    input  logic [HOLD_W-1:0] hold_len,
    output logic              free
);
    logic [HOLD_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (claim) begin
            remain <= hold_len - HOLD_W'(1);
        end else if (remain != '0) begin
            remain <= remain - HOLD_W'(1);
        end
    end

    assign free = (remain == '0);
endmodule

// File: rtl/dsb_div_timer.sv
module dsb_div_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] block_len,
    output logic             idle
);
    logic [CNT_W-1:0] count;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (start) begin
            count <= block_len;
        end else if (count != '0) begin
            count <= count - CNT_W'(1);
        end
    end

    assign idle = (count == '0);
endmodule

// File: rtl/dsb_route_pick.sv
module dsb_route_pick
    import dsb_pkg::*;
(
    input  op_route_t            route,
    input  logic [NUM_PORTS-1:0] port_free,
    output logic                 ok,
    output logic [NUM_PORTS-1:0] mask
);
    logic need_fits;
    logic alt_fits;

    assign need_fits = (route.need != '0) && ((route.need & ~port_free) == '0);
    assign alt_fits  = (route.alt  != '0) && ((route.alt  & ~port_free) == '0);

    always_comb begin
        ok   = 1'b0;
        mask = '0;
        if (route.legal) begin
            if (need_fits) begin
                ok   = 1'b1;
                mask = route.need;
            end else if (alt_fits) begin
                ok   = 1'b1;
                mask = route.alt;
            end
        end
    end
endmodule

// File: rtl/dispatch_scoreboard.sv
module dispatch_scoreboard
    import dsb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [CLASS_W-1:0]   req_class,
    input  logic [MODE_W-1:0]    req_mode,
    output logic                 grant,
    output logic [NUM_PORTS-1:0] grant_ports,
    output logic [LAT_W-1:0]     result_latency
);
    op_route_t            route;
    logic [NUM_PORTS-1:0] port_free;
    logic [NUM_PORTS-1:0] pick_mask;
    logic                 port_ok;
    logic                 idiv_idle;
    logic                 fdiv_idle;
    logic                 div_ok;

    assign route  = decode_op(req_class, req_mode);
    assign div_ok = (!route.uses_idiv || idiv_idle) && (!route.uses_fdiv || fdiv_idle);

    dsb_route_pick u_pick (
        .route     (route),
        .port_free (port_free),
        .ok        (port_ok),
        .mask      (pick_mask)
    );

    assign grant          = req_valid && route.legal && port_ok && div_ok;
    assign grant_ports    = grant ? pick_mask : '0;
    assign result_latency = grant ? route.latency : '0;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        dsb_port_hold #(.HOLD_W(HOLD_W)) u_hold (
            .clk      (clk),
            .rst      (rst),
            .claim    (grant_ports[p]),
            .hold_len (route.hold),
            .free     (port_free[p])
        );
    end

    dsb_div_timer #(.CNT_W(DIV_CNT_W)) u_idiv (
        .clk       (clk),
        .rst       (rst),
        .start     (grant && route.uses_idiv),
        .block_len (route.div_block),
        .idle      (idiv_idle)
    );

    dsb_div_timer #(.CNT_W(DIV_CNT_W)) u_fdiv (
        .clk       (clk),
        .rst       (rst),
        .start     (grant && route.uses_fdiv),
        .block_len (route.div_block),
        .idle      (fdiv_idle)
    );
endmodule

// File: rtl/dsb_checker.sv
module dsb_checker (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic [3:0] req_class,
    input logic [1:0] req_mode,
    input logic       grant,
    input logic [4:0] grant_ports,
    input logic [5:0] result_latency
);
    logic [5:0] idiv_gap;
    logic [5:0] idiv_need;
    logic [5:0] fdiv_gap;
    logic [5:0] fdiv_need;
    logic       idiv_go;
    logic       fdiv_go;

    assign idiv_go = grant && (req_class == 4'd8);
    assign fdiv_go = grant && (req_class == 4'd9);

    always_ff @(posedge clk) begin
        if (rst) begin
            idiv_gap  <= 6'd63;
            idiv_need <= 6'd0;
            fdiv_gap  <= 6'd63;
            fdiv_need <= 6'd0;
        end else begin
            if (idiv_go) begin
                idiv_gap  <= 6'd1;
                idiv_need <= (req_mode == 2'd0) ? 6'd12 : (req_mode == 2'd1) ? 6'd21 : 6'd37;
            end else if (idiv_gap != 6'd63) begin
                idiv_gap <= idiv_gap + 6'd1;
            end
            if (fdiv_go) begin
                fdiv_gap  <= 6'd1;
                fdiv_need <= (req_mode == 2'd0) ? 6'd17 : (req_mode == 2'd1) ? 6'd31 : 6'd37;
            end else if (fdiv_gap != 6'd63) begin
                fdiv_gap <= fdiv_gap + 6'd1;
            end
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> (!grant && grant_ports == 5'd0 && result_latency == 6'd0));

    p_alu_ports_r2: assert property (@(posedge clk) disable iff (rst)
        (grant && req_class == 4'd0) |-> (grant_ports == 5'b00001 || grant_ports == 5'b00010));

    p_single_port_r3: assert property (@(posedge clk) disable iff (rst)
        (grant && req_class != 4'd5) |-> ($countones(grant_ports) == 1));

    p_store_pair_r4: assert property (@(posedge clk) disable iff (rst)
        (grant && req_class == 4'd5) |-> (grant_ports == 5'b11000));

    p_imul_latency_r5: assert property (@(posedge clk) disable iff (rst)
        (grant && req_class == 4'd2) |-> (result_latency == 6'd4));

    p_idiv_window_r6: assert property (@(posedge clk) disable iff (rst)
        idiv_go |-> (idiv_gap >= idiv_need));

    p_fdiv_window_r7: assert property (@(posedge clk) disable iff (rst)
        fdiv_go |-> (fdiv_gap >= fdiv_need));

    p_fmul_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (grant && req_class == 4'd7) |=> !(grant && grant_ports[0]));

    p_undefined_r10: assert property (@(posedge clk) disable iff (rst)
        (req_class > 4'd9) |-> !grant);
endmodule

bind dispatch_scoreboard dsb_checker u_dsb_checker (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .req_class      (req_class),
    .req_mode       (req_mode),
    .grant          (grant),
    .grant_ports    (grant_ports),
    .result_latency (result_latency)
);

// File: tb/dispatch_scoreboard_bench.sv
`timescale 1ns/1ps
module dispatch_scoreboard_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [3:0] req_class = 4'd0;
    logic [1:0] req_mode = 2'd0;
    logic       grant;
    logic [4:0] grant_ports;
    logic [5:0] result_latency;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 1'b0;

    always #4 clk = ~clk;

    dispatch_scoreboard u_dispatch_scoreboard (
        .clk            (clk),
        .rst            (rst),
        .req_valid      (req_valid),
        .req_class      (req_class),
        .req_mode       (req_mode),
        .grant          (grant),
        .grant_ports    (grant_ports),
        .result_latency (result_latency)
    );

    typedef struct packed {
        logic [3:0] req;
        logic       v;
        logic [3:0] cls;
        logic [1:0] mode;
        logic       g;
        logic [4:0] m;
        logic [5:0] lat;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{4'd1,  1'b0, 4'd0,  2'd0, 1'b0, 5'b00000, 6'd0}, // R1 idle
        '{4'd2,  1'b1, 4'd0,  2'd0, 1'b1, 5'b00001, 6'd1}, // R2 ALU on port 0
        '{4'd3,  1'b1, 4'd1,  2'd0, 1'b1, 5'b00001, 6'd1}, // R3 shift
        '{4'd5,  1'b1, 4'd2,  2'd0, 1'b1, 5'b00001, 6'd4}, // R5 multiply
        '{4'd5,  1'b1, 4'd2,  2'd0, 1'b1, 5'b00001, 6'd4}, // R5 back to back
        '{4'd3,  1'b1, 4'd3,  2'd0, 1'b1, 5'b00010, 6'd1}, // R3 branch
        '{4'd3,  1'b1, 4'd4,  2'd0, 1'b1, 5'b00100, 6'd4}, // R3 load
        '{4'd4,  1'b1, 4'd5,  2'd0, 1'b1, 5'b11000, 6'd1}, // R4 store pair
        '{4'd5,  1'b1, 4'd6,  2'd0, 1'b1, 5'b00001, 6'd3}, // R5 fadd
        '{4'd5,  1'b1, 4'd7,  2'd0, 1'b1, 5'b00001, 6'd5}, // R5 fmul
        '{4'd2,  1'b1, 4'd0,  2'd0, 1'b1, 5'b00010, 6'd1}, // R2 fallback to port 1
        '{4'd2,  1'b1, 4'd0,  2'd0, 1'b1, 5'b00001, 6'd1}, // R2 port 0 reopened
        '{4'd8,  1'b1, 4'd7,  2'd0, 1'b1, 5'b00001, 6'd5}, // R8 fmul
        '{4'd8,  1'b1, 4'd1,  2'd0, 1'b0, 5'b00000, 6'd0}, // R8 port 0 held
        '{4'd8,  1'b1, 4'd1,  2'd0, 1'b1, 5'b00001, 6'd1}, // R8 port 0 free
        '{4'd10, 1'b1, 4'd12, 2'd0, 1'b0, 5'b00000, 6'd0}, // R10 undefined
        '{4'd8,  1'b1, 4'd7,  2'd0, 1'b1, 5'b00001, 6'd5}, // R8 fmul
        '{4'd10, 1'b1, 4'd15, 2'd0, 1'b0, 5'b00000, 6'd0}, // R10 undefined
        '{4'd4,  1'b1, 4'd5,  2'd0, 1'b1, 5'b11000, 6'd1}, // R4 store
        '{4'd3,  1'b1, 4'd3,  2'd0, 1'b1, 5'b00010, 6'd1}  // R3 branch
    };

    task automatic drive(input logic v, input logic [3:0] c, input logic [1:0] m);
        @(negedge clk);
        req_valid = v;
        req_class = c;
        req_mode  = m;
        #2;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(1'b0, 4'd0, 2'd0);
    endtask

    task automatic check(input int req, input logic g, input logic [4:0] m, input logic [5:0] lat);
        total++;
        if (grant !== g || grant_ports !== m || result_latency !== lat) begin
            bad++;
            $display("FAIL R%0d: grant/ports/lat got %b/%b/%0d expected %b/%b/%0d",
                     req, grant, grant_ports, result_latency, g, m, lat);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        req_valid = 1'b0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    // R6: window test for one integer mode (span n)
    task automatic idiv_window(input logic [1:0] mode, input int n);
        drive(1'b1, 4'd8, mode); check(6, 1'b1, 5'b00001, 6'(n));
        idle(n - 2);
        drive(1'b1, 4'd8, mode); check(6, 1'b0, 5'b00000, 6'd0);
        drive(1'b1, 4'd8, mode); check(6, 1'b1, 5'b00001, 6'(n));
        idle(n);
    endtask

    // R7: window test for one floating mode (latency lat, interval lat-1)
    task automatic fdiv_window(input logic [1:0] mode, input int lat);
        drive(1'b1, 4'd9, mode); check(7, 1'b1, 5'b00001, 6'(lat));
        idle(lat - 3);
        drive(1'b1, 4'd9, mode); check(7, 1'b0, 5'b00000, 6'd0);
        drive(1'b1, 4'd9, mode); check(7, 1'b1, 5'b00001, 6'(lat));
        idle(lat);
    endtask

    initial begin
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].v, VEC[i].cls, VEC[i].mode);
            check(int'(VEC[i].req), VEC[i].g, VEC[i].m, VEC[i].lat);
        end
        idle(2);

        // R6, R7, R9, R11: overlapping dividers, mode 0
        drive(1'b1, 4'd8, 2'd0); check(6, 1'b1, 5'b00001, 6'd12);
        drive(1'b1, 4'd9, 2'd0); check(9, 1'b1, 5'b00001, 6'd18);   // R9
        drive(1'b1, 4'd0, 2'd0); check(9, 1'b1, 5'b00001, 6'd1);    // R9
        idle(8);
        drive(1'b1, 4'd8, 2'd0); check(6, 1'b0, 5'b00000, 6'd0);    // R6 last busy
        drive(1'b1, 4'd8, 2'd0); check(11, 1'b1, 5'b00001, 6'd12);  // R11 not restarted
        idle(4);
        drive(1'b1, 4'd9, 2'd0); check(7, 1'b0, 5'b00000, 6'd0);    // R7 last busy
        drive(1'b1, 4'd9, 2'd0); check(7, 1'b1, 5'b00001, 6'd18);
        idle(40);

        idiv_window(2'd1, 21);
        idiv_window(2'd2, 37);
        idiv_window(2'd3, 37);
        fdiv_window(2'd1, 32);
        fdiv_window(2'd2, 38);
        fdiv_window(2'd3, 38);

        // R12: reset in the middle of occupancy
        drive(1'b1, 4'd8, 2'd2); check(12, 1'b1, 5'b00001, 6'd37);
        drive(1'b1, 4'd9, 2'd2); check(12, 1'b1, 5'b00001, 6'd38);
        drive(1'b1, 4'd7, 2'd0); check(12, 1'b1, 5'b00001, 6'd5);
        do_reset();
        drive(1'b1, 4'd1, 2'd0); check(12, 1'b1, 5'b00001, 6'd1);
        drive(1'b1, 4'd8, 2'd2); check(12, 1'b1, 5'b00001, 6'd37);
        drive(1'b1, 4'd9, 2'd2); check(12, 1'b1, 5'b00001, 6'd38);
        drive(1'b0, 4'd8, 2'd0); check(1, 1'b0, 5'b00000, 6'd0);    // R1

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete, got timeout expected finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule